// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds eight one-bit ownership tokens that two independent ports, left and right, use to take turns on shared resources. Both ports are synchronous to one clock. Each has an active-low semaphore select, a three-bit semaphore index, a write strobe, a single write-data bit and a read-data bus. A port asks for a token by writing 0 to it, gives it back by writing 1, and reads the token to learn whether it now holds it. A request that finds the token held by the other port is latched and stays pending. It is granted without further action on the cycle after the owner gives the token back.

Each token is a five-state machine. In `SEM_FREE` nobody holds the token. `SEM_LEFT` and `SEM_RIGHT` mean one port holds it. `SEM_LEFT_RWAIT` means the left port holds it and a right request is pending. `SEM_RIGHT_LWAIT` is the mirror case.

The transitions are:
- **Claim**: a request in `SEM_FREE` moves to `SEM_LEFT` or `SEM_RIGHT`. If both ports request in the same cycle, the state moves to `SEM_LEFT_RWAIT`.
- **Queue**: a request from the non-owner moves to the matching WAIT state.
- **Handover**: the owner's release in a WAIT state moves ownership to the waiting port.
- **Drop**: the owner's release with no waiter returns to `SEM_FREE`.
- **Cancel**: the waiter's release in a WAIT state returns to the owner-only state.
- **Double release**: both ports releasing together in a WAIT state return to `SEM_FREE`.

A release in a state where the port neither holds nor waits has no effect.

Top module: `dual_port_semaphore`

## Requirements
- R1: After reset all eight tokens are free and no request is pending. A read of any index by either port returns 1 on bit 0.
- R2: A port's write or read acts only in a cycle where its select input is low. A write with select high changes no token.
- R3: The index input picks the token. A write to one index leaves the other seven unchanged.
- R4: A write with data bit 0 is a request. The port takes the token on the next cycle if it is free.
- R5: A write with data bit 1 is a release. It removes the writing port's ownership or its pending request.
- R6: A read issued in cycle N shows its result on the read bus after the clock edge that ends cycle N. Bit 0 is 0 if the reading port held the token during cycle N and 1 otherwise. All upper bits are 1. When no read is issued, the whole bus is all ones.
- R7: A request that finds the token held by the other port stays pending. It becomes ownership on the cycle after the owner releases.
- R8: When both ports request a free token in the same cycle, the left port gets it and the right request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_n | input | 1 | Left select, active low |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_idx | input | 3 | Left token index |
| l_wbit | input | 1 | Left write bit (0 request, 1 release) |
| l_rdata | output | DATA_W | Left read result, registered |
| r_sem_n | input | 1 | Right select, active low |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_idx | input | 3 | Right token index |
| r_wbit | input | 1 | Right write bit (0 request, 1 release) |
| r_rdata | output | DATA_W | Right read result, registered |

## Verification
The assertions assume each port issues at most one operation per cycle, which the single write strobe guarantees. They also assume the index inputs are stable across the clock edge in any cycle where select is low. The stimulus changes every input only on the falling clock edge. It holds select high on idle cycles, so no unintended operation reaches a token. Simultaneous operations are placed only where a requirement calls for them: same-cycle requests, and a release in the same cycle as a waiting request.

// File: rtl/sem_pkg.sv
package sem_pkg;
    localparam int NUM_SEM = 8;
    localparam int SEL_W   = $clog2(NUM_SEM);

    typedef enum logic [2:0] {
        SEM_FREE        = 3'd0,
        SEM_LEFT        = 3'd1,
        SEM_RIGHT       = 3'd2,
        SEM_LEFT_RWAIT  = 3'd3,
        SEM_RIGHT_LWAIT = 3'd4
    } sem_state_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_pkg::*;
(
    input  logic                 sem_n,
    input  logic                 we,
    input  logic [SEL_W-1:0]     idx,
    input  logic                 wbit,
    output logic [NUM_SEM-1:0]   req,
    output logic [NUM_SEM-1:0]   rel,
    output logic                 rd_en,
    output logic [SEL_W-1:0]     rd_idx
);
    logic active_wr;

    assign active_wr = !sem_n && we;
    assign rd_en     = !sem_n && !we;
    assign rd_idx    = idx;

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
        logic hit;
        assign hit    = active_wr && (idx == SEL_W'(g));
        assign req[g] = hit && !wbit;
        assign rel[g] = hit && wbit;
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic own_l,
    output logic own_r
);
    sem_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEM_FREE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SEM_FREE: begin
                if (l_req)      nxt = r_req ? SEM_LEFT_RWAIT : SEM_LEFT;
                else if (r_req) nxt = SEM_RIGHT;
            end
            SEM_LEFT: begin
                if (l_rel)      nxt = r_req ? SEM_RIGHT : SEM_FREE;
                else if (r_req) nxt = SEM_LEFT_RWAIT;
            end
            SEM_LEFT_RWAIT: begin
                if (l_rel)      nxt = r_rel ? SEM_FREE : SEM_RIGHT;
                else if (r_rel) nxt = SEM_LEFT;
            end
            SEM_RIGHT: begin
                if (r_rel)      nxt = l_req ? SEM_LEFT : SEM_FREE;
                else if (l_req) nxt = SEM_RIGHT_LWAIT;
            end
            SEM_RIGHT_LWAIT: begin
                if (r_rel)      nxt = l_rel ? SEM_FREE : SEM_LEFT;
                else if (l_rel) nxt = SEM_RIGHT;
            end
            default: nxt = SEM_FREE;
        endcase
    end

    always_comb begin
        own_l = (state == SEM_LEFT)  || (state == SEM_LEFT_RWAIT);
        own_r = (state == SEM_RIGHT) || (state == SEM_RIGHT_LWAIT);
    end

    assert_left_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEM_FREE && l_req && r_req) |=> (own_l && state == SEM_LEFT_RWAIT));
    assert_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEM_FREE && l_req) |=> own_l);
    assert_handover_to_r_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEM_LEFT_RWAIT && l_rel && !r_rel) |=> own_r);
    assert_handover_to_l_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEM_RIGHT_LWAIT && r_rel && !l_rel) |=> own_l);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l && !l_rel) |=> own_l);
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_r && r_rel) |=> !own_r);
endmodule

// File: rtl/sem_readback.sv
module sem_readback
    import sem_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [SEL_W-1:0]   rd_idx,
    input  logic [NUM_SEM-1:0] own,
    output logic [DATA_W-1:0]  rdata
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= ALL_ONES;
        else if (rd_en) rdata <= {ALL_ONES[DATA_W-1:1], ~own[rd_idx]};
        else            rdata <= ALL_ONES;
    end

    assert_idle_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == ALL_ONES));
    assert_upper_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rdata[DATA_W-1:1] == ALL_ONES[DATA_W-1:1]));
endmodule

// File: rtl/dual_port_semaphore.sv
module dual_port_semaphore
    import sem_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sem_n,
    input  logic              l_we,
    input  logic [SEL_W-1:0]  l_idx,
    input  logic              l_wbit,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_n,
    input  logic              r_we,
    input  logic [SEL_W-1:0]  r_idx,
    input  logic              r_wbit,
    output logic [DATA_W-1:0] r_rdata
);
    logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_SEM-1:0] own_l, own_r;
    logic               l_rd_en, r_rd_en;
    logic [SEL_W-1:0]   l_rd_idx, r_rd_idx;

    sem_port_decode u_dec_l (
        .sem_n(l_sem_n), .we(l_we), .idx(l_idx), .wbit(l_wbit),
        .req(l_req), .rel(l_rel), .rd_en(l_rd_en), .rd_idx(l_rd_idx)
    );

    sem_port_decode u_dec_r (
        .sem_n(r_sem_n), .we(r_we), .idx(r_idx), .wbit(r_wbit),
        .req(r_req), .rel(r_rel), .rd_en(r_rd_en), .rd_idx(r_rd_idx)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[g]), .l_rel(l_rel[g]),
            .r_req(r_req[g]), .r_rel(r_rel[g]),
            .own_l(own_l[g]), .own_r(own_r[g])
        );
    end

    sem_readback #(.DATA_W(DATA_W)) u_rb_l (
        .clk(clk), .rst_n(rst_n), .rd_en(l_rd_en), .rd_idx(l_rd_idx),
        .own(own_l), .rdata(l_rdata)
    );

    sem_readback #(.DATA_W(DATA_W)) u_rb_r (
        .clk(clk), .rst_n(rst_n), .rd_en(r_rd_en), .rd_idx(r_rd_idx),
        .own(own_r), .rdata(r_rdata)
    );

    assert_ghost_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sem_n && r_sem_n) |=> ((own_l == $past(own_l)) && (own_r == $past(own_r))));
endmodule

// File: tb/dual_port_semaphore_tb.sv
module dual_port_semaphore_tb_top;
    localparam int PERIOD = 10;
    localparam int DW     = 8;
    localparam int OP_IDLE = 0, OP_REQ = 1, OP_REL = 2, OP_RD = 3, OP_GHOST = 4;

    typedef struct {
        int            due;
        bit            right;
        logic [DW-1:0] exp;
        string         tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sem_n = 1'b1, l_we = 1'b0, l_wbit = 1'b1;
    logic r_sem_n = 1'b1, r_we = 1'b0, r_wbit = 1'b1;
    logic [2:0] l_idx = '0, r_idx = '0;
    logic [DW-1:0] l_rdata, r_rdata;

    int    cyc = 0;
    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    item_t q[$];

    dual_port_semaphore #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_sem_n(l_sem_n), .l_we(l_we), .l_idx(l_idx), .l_wbit(l_wbit), .l_rdata(l_rdata),
        .r_sem_n(r_sem_n), .r_we(r_we), .r_idx(r_idx), .r_wbit(r_wbit), .r_rdata(r_rdata)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] expect_of(int op, int bit0);
        if (op == OP_RD) return {{(DW-1){1'b1}}, 1'(bit0)};
        return '1;
    endfunction

    task automatic report(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus on both ports; expected read results queued
    task automatic tick(int lop, int la, int lexp, int rop, int ra, int rexp, string tag);
        item_t it;
        @(negedge clk);
        l_sem_n = !(lop == OP_REQ || lop == OP_REL || lop == OP_RD);
        l_we    = (lop == OP_REQ || lop == OP_REL || lop == OP_GHOST);
        l_wbit  = (lop == OP_REL);
        l_idx   = 3'(la);
        r_sem_n = !(rop == OP_REQ || rop == OP_REL || rop == OP_RD);
        r_we    = (rop == OP_REQ || rop == OP_REL || rop == OP_GHOST);
        r_wbit  = (rop == OP_REL);
        r_idx   = 3'(ra);
        it.due = cyc + 1; it.right = 1'b0; it.exp = expect_of(lop, lexp);
        it.tag = {tag, " left"};  q.push_back(it);
        it.due = cyc + 1; it.right = 1'b1; it.exp = expect_of(rop, rexp);
        it.tag = {tag, " right"}; q.push_back(it);
    endtask

    // monitor: compare registered read data a quarter period after the edge
    always @(posedge clk) begin
        #(PERIOD/4);
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            report(it.tag, it.right ? r_rdata : l_rdata, it.exp);
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        report("R1 reset bus left", l_rdata, '1);
        report("R1 reset bus right", r_rdata, '1);
        for (int i = 0; i < 8; i++) tick(OP_RD, i, 1, OP_RD, 7 - i, 1, "R1 free after reset");
        // R4 request free token, R6 read result
        tick(OP_REQ, 2, 0, OP_IDLE, 0, 0, "R4 left request 2");
        tick(OP_RD, 2, 0, OP_RD, 2, 1, "R6 owner reads 0, other reads 1");
        // R2 write with select high has no effect
        tick(OP_IDLE, 0, 0, OP_GHOST, 5, 0, "R2 ghost write");
        tick(OP_IDLE, 0, 0, OP_RD, 5, 1, "R2 token 5 still free");
        // R3 index picks only its token
        tick(OP_IDLE, 0, 0, OP_REQ, 5, 0, "R3 right request 5");
        tick(OP_RD, 5, 1, OP_RD, 5, 0, "R3 token 5 owned by right");
        tick(OP_RD, 4, 1, OP_RD, 6, 1, "R3 neighbours free");
        tick(OP_RD, 2, 0, OP_RD, 4, 1, "R3 token 2 still left");
        // R7 pending request and handover
        tick(OP_IDLE, 0, 0, OP_REQ, 2, 0, "R7 right queues on 2");
        tick(OP_RD, 2, 0, OP_RD, 2, 1, "R7 right pending");
        tick(OP_REL, 2, 0, OP_IDLE, 0, 0, "R7 left releases 2");
        tick(OP_RD, 2, 1, OP_RD, 2, 0, "R7 right granted after release");
        tick(OP_IDLE, 0, 0, OP_REL, 2, 0, "R5 right releases 2");
        tick(OP_RD, 2, 1, OP_RD, 2, 1, "R5 token 2 free");
        // R8 simultaneous request, left wins
        tick(OP_REQ, 7, 0, OP_REQ, 7, 0, "R8 both request 7");
        tick(OP_RD, 7, 0, OP_RD, 7, 1, "R8 left wins");
        tick(OP_REL, 7, 0, OP_IDLE, 0, 0, "R8 left releases 7");
        tick(OP_RD, 7, 1, OP_RD, 7, 0, "R8 right got 7");
        // R5 pending request cancelled by release
        tick(OP_REQ, 5, 0, OP_IDLE, 0, 0, "R5 left queues on 5");
        tick(OP_REL, 5, 0, OP_IDLE, 0, 0, "R5 left cancels 5");
        tick(OP_IDLE, 0, 0, OP_REL, 5, 0, "R5 right releases 5");
        tick(OP_RD, 5, 1, OP_RD, 5, 1, "R5 cancelled request not granted");
        // R5 release of token not held is ignored
        tick(OP_REL, 7, 0, OP_IDLE, 0, 0, "R5 stray release");
        tick(OP_RD, 7, 1, OP_RD, 7, 0, "R5 right keeps 7");
        // R3 independent tokens on both ports
        tick(OP_REQ, 0, 0, OP_REQ, 4, 0, "R3 left 0, right 4");
        tick(OP_REQ, 1, 0, OP_IDLE, 0, 0, "R3 left 1");
        tick(OP_RD, 0, 0, OP_RD, 4, 0, "R3 both own");
        tick(OP_RD, 1, 0, OP_RD, 1, 1, "R3 left owns 1");
        tick(OP_RD, 4, 1, OP_RD, 0, 1, "R3 cross reads");
        tick(OP_IDLE, 0, 0, OP_IDLE, 0, 0, "R6 idle bus ones");
        tick(OP_IDLE, 0, 0, OP_IDLE, 0, 0, "R6 drain");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule